// File: doc/BRIEF.md
# Lockable Presence-Detect Store with Two-Wire Target

This block is a two-wire serial (I2C) target that holds a 512-byte configuration store for a memory module. The bus host can write single bytes and read back any number of bytes in a row. The store is divided into four 128-byte blocks. A software lock can close the lower three blocks to writes, and the same mechanism can open them again. The top block never locks. Three strap inputs give the target its position in the bus address range, so several modules can share one bus.

Some operations happen over time. After each accepted write, the target is busy for a write-cycle period. During that period it refuses its address, so the host can poll until the write completes. After reset, it also refuses all traffic for an initialisation period. If the clock line stays low for too long during a transfer, the engine drops the transfer and releases the data line. The bus lines are sampled with the system clock. The data line is driven open-drain through a single pull-low output.

Byte addressing uses a one-byte word address joined to a page bit, which picks the lower or upper 256-byte half. During a read, the byte pointer steps forward after every byte and wraps from the last byte back to byte 0.

Top module: `spd_target`

## Requirements
- R1: After reset the data line is released. Until INIT_CYC cycles have passed, every address byte gets a NACK.
- R2: A memory address byte is 1010 followed by strap bits [2:0] (most significant first), then R/W (1 = read). It gets an ACK only when the three address bits equal strap_i. Any other value gets a NACK.
- R3: A byte write (address byte, word byte, data byte) stores the data byte. A following random read (address byte, word byte, repeated start, read address byte) returns it.
- R4: A read returns the byte at the pointer and then adds one to the pointer. Consecutive read bytes come from consecutive addresses, and the pointer wraps from 511 to 0.
- R5: Control byte 0110_110_0 selects page 0, and 0110_111_0 selects page 1. The byte address is {page, word byte}.
- R6: A stop or repeated start that follows an accepted data byte starts a WRITE_CYC write cycle. Until that cycle ends, every address byte gets a NACK.
- R7: Control byte 0110_011_0 sets the lock. While the lock is set, a data byte aimed at addresses 0 to 383 gets a NACK and the store is unchanged. Addresses 384 to 511 still accept writes.
- R8: Control byte 0110_001_0 clears the lock, and addresses 0 to 383 accept writes again.
- R9: Only one data byte is accepted per transfer. A second data byte gets a NACK and is not stored.
- R10: If the clock line stays low for TIMEOUT_CYC cycles while a transfer is open, the data line is released and the engine goes idle. The next start condition is served normally.
- R11: A stop condition returns the engine to idle with the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 3 | Strap bits that set the address within the bus range |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |

## Verification
A wrong internal pointer or page bit shows at the ports on the very next read byte, because the returned data comes from the wrong address. A lock or busy flag stuck in the wrong state shows in the ACK slot of the next data byte or address byte, within one byte time of the bus. A timeout counter that never expires leaves the pull-low output asserted for as long as the clock line stays low. A counter that fires too early drops a normal transfer in the middle of a byte.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_WORD, PH_DATA, PH_READ, PH_SKIP
  } phase_t;

  localparam logic [3:0] MEM_TYPE   = 4'b1010;
  localparam logic [3:0] CTL_TYPE   = 4'b0110;
  localparam logic [2:0] CTL_UNLOCK = 3'b001;
  localparam logic [2:0] CTL_LOCK   = 3'b011;
  localparam logic [2:0] CTL_PAGE0  = 3'b110;
  localparam logic [2:0] CTL_PAGE1  = 3'b111;
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_s, sda_s;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[STAGES-2:0], scl_i};
      sda_s <= {sda_s[STAGES-2:0], sda_i};
      scl_d <= scl_s[STAGES-1];
      sda_d <= sda_s[STAGES-1];
    end
  end

  assign scl_lvl  = scl_s[STAGES-1];
  assign sda_lvl  = sda_s[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/spd_timers.sv
module spd_timers #(
  parameter int INIT_CYC    = 1000,
  parameter int WRITE_CYC   = 600,
  parameter int TIMEOUT_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic scl_lvl,
  input  logic start_busy,
  output logic init_done,
  output logic busy,
  output logic tmo
);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam int WW = $clog2(WRITE_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [IW-1:0] init_cnt;
  logic [WW-1:0] busy_cnt;
  logic [TW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      init_cnt  <= init_cnt + 1'b1;
      init_done <= (init_cnt == IW'(INIT_CYC - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
    end else if (start_busy) begin
      busy_cnt <= WW'(WRITE_CYC);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end
  assign busy = (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      tmo     <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (!active || scl_lvl || tmo) begin
        low_cnt <= '0;
      end else if (low_cnt == TW'(TIMEOUT_CYC - 1)) begin
        low_cnt <= '0;
        tmo     <= 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [DW-1:0]            wd,
  input  logic [$clog2(DEPTH)-1:0] ra,
  output logic [DW-1:0]            rq
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/spd_target.sv
module spd_target
  import spd_pkg::*;
#(
  parameter int DEPTH         = 512,
  parameter int BLOCKS        = 4,
  parameter int LOCKED_BLOCKS = 3,
  parameter int INIT_CYC      = 1000000,
  parameter int WRITE_CYC     = 500000,
  parameter int TIMEOUT_CYC   = 3000000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PG_W = AW - 8;
  localparam logic [AW-1:0] LOCK_LIM = AW'((DEPTH / BLOCKS) * LOCKED_BLOCKS);
  localparam logic [AW-1:0] ONE      = AW'(1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic init_done, busy, tmo, start_busy;

  phase_t         phase, nxt_q, nxt_c;
  logic [3:0]     cnt;
  logic [7:0]     sh;
  logic [AW-1:0]  ptr;
  logic [PG_W-1:0] page;
  logic           wp_q, taken, hack;
  logic           we_q;
  logic [AW-1:0]  wa_q;
  logic [7:0]     wd_q, rq;
  logic           ack_c, dev_hit, ctl_hit, locked;

  spd_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  spd_timers #(.INIT_CYC(INIT_CYC), .WRITE_CYC(WRITE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) i_tmr (
    .clk(clk), .rst(rst), .active(phase != PH_IDLE), .scl_lvl(scl_lvl),
    .start_busy(start_busy), .init_done(init_done), .busy(busy), .tmo(tmo)
  );

  spd_store #(.DEPTH(DEPTH), .DW(8)) i_store (
    .clk(clk), .we(we_q), .wa(wa_q), .wd(wd_q), .ra(ptr), .rq(rq)
  );

  // ACK decision for the byte just shifted in
  always_comb begin
    dev_hit = (sh[7:4] == MEM_TYPE) && (sh[3:1] == strap_i);
    ctl_hit = 1'b0;
    if (sh[7:4] == CTL_TYPE && !sh[0]) begin
      case (sh[3:1])
        CTL_UNLOCK, CTL_LOCK, CTL_PAGE0, CTL_PAGE1: ctl_hit = 1'b1;
        default: ctl_hit = 1'b0;
      endcase
    end
    locked = wp_q && (ptr < LOCK_LIM);
    ack_c  = 1'b0;
    nxt_c  = PH_SKIP;
    case (phase)
      PH_DEV: begin
        ack_c = init_done && !busy && (dev_hit || ctl_hit);
        if (ack_c && dev_hit) nxt_c = sh[0] ? PH_READ : PH_WORD;
      end
      PH_WORD: begin
        ack_c = 1'b1;
        nxt_c = PH_DATA;
      end
      PH_DATA: begin
        ack_c = !taken && !locked;
        if (ack_c) nxt_c = PH_DATA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      nxt_q      <= PH_IDLE;
      cnt        <= '0;
      sh         <= '0;
      sda_pull_o <= 1'b0;
      ptr        <= '0;
      page       <= '0;
      wp_q       <= 1'b0;
      taken      <= 1'b0;
      hack       <= 1'b1;
      we_q       <= 1'b0;
      wa_q       <= '0;
      wd_q       <= '0;
      start_busy <= 1'b0;
    end else begin
      we_q       <= 1'b0;
      start_busy <= 1'b0;
      if (tmo) begin
        phase      <= PH_IDLE;
        sda_pull_o <= 1'b0;
        cnt        <= '0;
        start_busy <= taken;
        taken      <= 1'b0;
      end else if (start_ev) begin
        phase      <= PH_DEV;
        sda_pull_o <= 1'b0;
        cnt        <= '0;
        start_busy <= taken;
        taken      <= 1'b0;
      end else if (stop_ev) begin
        phase      <= PH_IDLE;
        sda_pull_o <= 1'b0;
        cnt        <= '0;
        start_busy <= taken;
        taken      <= 1'b0;
      end else if (phase == PH_READ) begin
        if (scl_rise && cnt < 4'd9) begin
          if (cnt == 4'd8) hack <= sda_lvl;
          cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_pull_o <= 1'b0;
          end else if (cnt == 4'd9) begin
            if (!hack) begin
              sh         <= rq;
              sda_pull_o <= ~rq[7];
              ptr        <= ptr + ONE;
              cnt        <= '0;
            end else begin
              sda_pull_o <= 1'b0;
              phase      <= PH_SKIP;
            end
          end else if (cnt != 4'd0) begin
            sh         <= {sh[6:0], 1'b0};
            sda_pull_o <= ~sh[6];
          end
        end
      end else if (phase == PH_DEV || phase == PH_WORD || phase == PH_DATA) begin
        if (scl_rise && cnt < 4'd8) begin
          sh  <= {sh[6:0], sda_lvl};
          cnt <= cnt + 4'd1;
        end else if (scl_fall && cnt == 4'd8) begin
          sda_pull_o <= ack_c;
          nxt_q      <= nxt_c;
          cnt        <= 4'd9;
          if (ack_c) begin
            case (phase)
              PH_DEV: if (!dev_hit) begin
                case (sh[3:1])
                  CTL_LOCK:   wp_q <= 1'b1;
                  CTL_UNLOCK: wp_q <= 1'b0;
                  CTL_PAGE0:  page <= PG_W'(0);
                  CTL_PAGE1:  page <= PG_W'(1);
                  default: ;
                endcase
              end
              PH_WORD: ptr <= {page, sh};
              PH_DATA: begin
                we_q  <= 1'b1;
                wa_q  <= ptr;
                wd_q  <= sh;
                ptr   <= ptr + ONE;
                taken <= 1'b1;
              end
              default: ;
            endcase
          end
        end else if (scl_fall && cnt == 4'd9) begin
          phase <= nxt_q;
          cnt   <= '0;
          if (nxt_q == PH_READ) begin
            sh         <= rq;
            sda_pull_o <= ~rq[7];
            ptr        <= ptr + ONE;
          end else begin
            sda_pull_o <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spd_target_chk.sv
module spd_target_chk #(
  parameter int DEPTH         = 512,
  parameter int BLOCKS        = 4,
  parameter int LOCKED_BLOCKS = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sda_pull_o,
  input logic                     init_done,
  input logic                     busy,
  input logic                     we_q,
  input logic                     wp_q,
  input logic                     tmo,
  input logic                     stop_ev,
  input logic [$clog2(DEPTH)-1:0] wa_q
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LIMIT = AW'((DEPTH / BLOCKS) * LOCKED_BLOCKS);

  // R1
  init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !sda_pull_o);

  // R6
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !we_q);

  // R7
  lock_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (we_q && wp_q) |-> (wa_q >= LIMIT));

  // R10
  tmo_release_chk: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !sda_pull_o);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_pull_o);
endmodule

bind spd_target spd_target_chk #(
  .DEPTH(DEPTH), .BLOCKS(BLOCKS), .LOCKED_BLOCKS(LOCKED_BLOCKS)
) i_chk (
  .clk(clk), .rst(rst), .sda_pull_o(sda_pull_o), .init_done(init_done),
  .busy(busy), .we_q(we_q), .wp_q(wp_q), .tmo(tmo), .stop_ev(stop_ev),
  .wa_q(wa_q)
);

// File: tb/test_spd_target.sv
module test_spd_target;
  localparam int INIT_CYC = 1000;
  localparam int WRITE_CYC = 600;
  localparam int TIMEOUT_CYC = 400;
  localparam int HP = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic pull;
  wire  line = sda_h & ~pull;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int exp_q[$];
  string tag_q[$];
  int act_q[$];
  logic [7:0] model [512];

  always #2 clk = ~clk;

  spd_target #(.INIT_CYC(INIT_CYC), .WRITE_CYC(WRITE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) i_spd_target (
    .clk(clk), .rst(rst), .strap_i(STRAP), .scl_i(scl_h), .sda_i(line), .sda_pull_o(pull)
  );

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic want(input string tag, input int v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  task automatic got(input int v);
    act_q.push_back(v);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        int a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (a != e) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", t, a, e);
        end
      end
    end
  end

  task automatic start_c();
    if (scl_h == 1'b0) begin
      sda_h = 1'b1; wt(HP/2);
      scl_h = 1'b1; wt(HP);
    end
    sda_h = 1'b0; wt(HP);
    scl_h = 1'b0; wt(HP/2);
  endtask

  task automatic stop_c();
    sda_h = 1'b0; wt(HP/2);
    scl_h = 1'b1; wt(HP);
    sda_h = 1'b1; wt(HP);
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wt(HP/2);
      scl_h = 1'b1; wt(HP);
      scl_h = 1'b0; wt(HP/2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b);
    sda_h = 1'b1; wt(HP/2);
    scl_h = 1'b1; wt(HP/2);
    got(line ? 0 : 1);
    wt(HP/2);
    scl_h = 1'b0; wt(HP/2);
  endtask

  task automatic recv_byte(input bit more);
    logic [7:0] b;
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_h = 1'b1; wt(HP/2);
      b[i] = line; wt(HP/2);
      scl_h = 1'b0; wt(HP);
    end
    got(int'(b));
    sda_h = more ? 1'b0 : 1'b1; wt(HP/2);
    scl_h = 1'b1; wt(HP);
    scl_h = 1'b0; wt(HP/2);
    sda_h = 1'b1;
  endtask

  task automatic ctl(input logic [2:0] code, input string tag);
    start_c();
    want(tag, 1); send_byte({4'b0110, code, 1'b0});
    stop_c();
  endtask

  task automatic set_page(input int a);
    ctl((a >= 256) ? 3'b111 : 3'b110, "R5 page select ack");
  endtask

  task automatic wr(input int a, input logic [7:0] d, input int dack, input string tag);
    set_page(a);
    start_c();
    want(tag, 1); send_byte(DEVW);
    want(tag, 1); send_byte(a[7:0]);
    want(tag, dack); send_byte(d);
    stop_c();
    if (dack == 1) begin
      model[a] = d;
      wt(WRITE_CYC + 50);
    end
  endtask

  task automatic rd(input int a, input int n, input string tag);
    set_page(a);
    start_c();
    want(tag, 1); send_byte(DEVW);
    want(tag, 1); send_byte(a[7:0]);
    start_c();
    want(tag, 1); send_byte(DEVR);
    for (int k = 0; k < n; k++) begin
      want(tag, int'(model[(a + k) % 512]));
      recv_byte(k < n - 1);
    end
    stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wt(10);
    rst = 1'b0;
    wt(2);
    // R1 reset state
    want("R1 line released after reset", 0); got(int'(pull));
    // R1 init window
    start_c();
    want("R1 nack during init", 0); send_byte(DEVW);
    stop_c();
    wt(INIT_CYC + 200);
    // R2 strap mismatch
    start_c();
    want("R2 wrong strap nack", 0); send_byte({4'b1010, 3'b010, 1'b0});
    stop_c();
    // R3 byte write and random read
    wr(5, 8'h3C, 1, "R3 write");
    wr(6, 8'hA5, 1, "R3 write");
    wr(7, 8'h5A, 1, "R3 write");
    rd(5, 1, "R3 random read");
    // R4 sequential read increments
    rd(5, 3, "R4 sequential read");
    // R9 second data byte rejected
    wr(8'h21, 8'h77, 1, "R9 setup");
    set_page(8'h20);
    start_c();
    want("R9 dev", 1); send_byte(DEVW);
    want("R9 word", 1); send_byte(8'h20);
    want("R9 first data ack", 1); send_byte(8'h11);
    want("R9 second data nack", 0); send_byte(8'h22);
    stop_c();
    model[8'h20] = 8'h11;
    wt(WRITE_CYC + 50);
    rd(8'h20, 2, "R9 readback");
    // R6 busy polling
    start_c();
    want("R6 dev", 1); send_byte(DEVW);
    want("R6 word", 1); send_byte(8'h30);
    want("R6 data", 1); send_byte(8'h99);
    stop_c();
    model[8'h30] = 8'h99;
    start_c();
    want("R6 nack while busy", 0); send_byte(DEVW);
    stop_c();
    wt(WRITE_CYC + 50);
    start_c();
    want("R6 ack after busy", 1); send_byte(DEVW);
    stop_c();
    want("R11 released after stop", 0); got(int'(pull));
    rd(8'h30, 1, "R6 readback");
    // R5 pages
    wr(9'h110, 8'hC3, 1, "R5 write page1");
    wr(9'h010, 8'h3E, 1, "R5 write page0");
    rd(9'h010, 1, "R5 read page0");
    rd(9'h110, 1, "R5 read page1");
    // R4 wrap
    wr(511, 8'hE1, 1, "R4 write top");
    wr(0, 8'h1E, 1, "R4 write bottom");
    rd(511, 2, "R4 wrap read");
    // R7 lock
    ctl(3'b011, "R7 lock ack");
    wr(5, 8'h00, 0, "R7 locked low nack");
    rd(5, 1, "R7 unchanged");
    wr(383, 8'h00, 0, "R7 boundary 383 nack");
    wr(384, 8'h4B, 1, "R7 384 open");
    rd(384, 1, "R7 384 readback");
    // R8 unlock
    ctl(3'b001, "R8 unlock ack");
    wr(5, 8'h66, 1, "R8 write after unlock");
    rd(5, 1, "R8 readback");
    // R10 timeout
    start_c();
    want("R10 dev", 1); send_byte(DEVW);
    send_bits(8'h40);
    wt(HP/2);
    want("R10 ack held", 1); got(int'(pull));
    wt(TIMEOUT_CYC + 40);
    want("R10 released after timeout", 0); got(int'(pull));
    start_c();
    want("R10 served after timeout", 1); send_byte(DEVW);
    stop_c();
    wait (act_q.size() == 0);
    wt(4);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule